// File: doc/BRIEF.md
# Staged Multi-Mode Word Shifter

This block moves the bits of a 32-bit word by any distance from 0 to 31 in a single combinational pass. The distance is resolved one binary digit at a time. A chain of five stages applies fixed moves of 1, 2, 4, 8 and 16 positions. Each stage either applies its move or passes its input straight through, and the matching bit of the distance decides which.

A 2-bit mode input selects what fills the vacated positions and which way the bits travel: zeros from the top, copies of the original sign bit from the top, zeros from the bottom, or the bits pushed out at the bottom wrapping round to the top. Every stage is shared by all four modes. Only the fill source and the direction change between modes.

The block is meant to sit inside an execution datapath as the shift unit of an arithmetic-logic unit. The result is valid in the same cycle as the operands, and the block holds no state.

Top module: `barrel_shift_stages`

## Requirements
- R1: With mode 2'b00 (logical right), output bit i equals input bit i+amt when i+amt < 32, and is 0 otherwise.
- R2: With mode 2'b01 (arithmetic right), output bit i equals input bit i+amt when i+amt < 32, and otherwise equals bit 31 of the input word.
- R3: With mode 2'b10 (logical left), output bit i equals input bit i-amt when i >= amt, and is 0 otherwise.
- R4: With mode 2'b11 (rotate right), output bit i equals input bit (i+amt) mod 32, so no bit is lost.
- R5: A shift amount of 0 returns the input word unchanged in every mode.
- R6: A shift whose amount has several bits set gives the same word as applying the component power-of-two shifts one after another in the same mode. For example, a distance of 3 equals a distance of 2 followed by a distance of 1.
- R7: The output follows a change of any input with no clock edge involved, because the block contains no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | 32 | Word to be shifted |
| amt  | input  | 5  | Shift distance, 0 to 31 |
| mode | input  | 2  | 00 logical right, 01 arithmetic right, 10 logical left, 11 rotate right |
| dout | output | 32 | Shifted word |

## Verification
The two functions that can act in the same evaluation are the sign fill and a full cascade in which all five stages shift at once. This is provoked with a negative word and a distance of 31 in arithmetic mode: every stage must copy the original bit 31, and no stage may copy a bit that an earlier stage has already shifted in. A negative word rotated by 31 is also checked, because every stage wraps at the same time. Each result is compared with a bit-by-bit model in the bench, and many seeded random words, distances and modes are run against that model as well.

// File: rtl/barrel_shift_stages.sv
module barrel_shift_stages #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    mode,
  output logic [W-1:0]  dout
);

  localparam logic [1:0] M_LSR = 2'b00;
  localparam logic [1:0] M_ASR = 2'b01;
  localparam logic [1:0] M_LSL = 2'b10;
  localparam logic [1:0] M_ROR = 2'b11;

  logic [W-1:0] st [0:AW];
  logic         sgn;

  assign st[0] = din;
  assign sgn   = din[W-1];

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 2 ** k;
    logic [W-1:0] moved;

    always_comb begin
      case (mode)
        M_ASR:   moved = {{S{sgn}}, st[k][W-1:S]};
        M_LSL:   moved = {st[k][W-S-1:0], {S{1'b0}}};
        M_ROR:   moved = {st[k][S-1:0], st[k][W-1:S]};
        M_LSR:   moved = {{S{1'b0}}, st[k][W-1:S]};
        default: moved = st[k];
      endcase
    end

    assign st[k+1] = amt[k] ? moved : st[k];
  end

  assign dout = st[AW];

endmodule

module barrel_shift_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic [W-1:0]  din,
  input logic [AW-1:0] amt,
  input logic [1:0]    mode,
  input logic [W-1:0]  dout
);

  logic [W-1:0] ror_ref;
  logic [W-1:0] asr_ref;
  assign ror_ref = (din >> amt) | (din << (W - int'(amt)));
  assign asr_ref = W'($signed(din) >>> amt);

  always_comb begin
    if (!$isunknown({din, amt, mode})) begin
      if (mode == 2'b00) p_lsr_zero_fill_r1: assert (dout == (din >> amt));
      if (mode == 2'b01) p_asr_sign_fill_r2: assert (dout == asr_ref);
      if (mode == 2'b10) p_lsl_zero_fill_r3: assert (dout == (din << amt));
      if (mode == 2'b11) p_ror_wrap_r4:      assert (dout == ror_ref);
      if (amt == '0)     p_zero_identity_r5: assert (dout == din);
      if (mode == 2'b11) p_ror_keeps_ones_r4: assert ($countones(dout) == $countones(din));
    end
  end

endmodule

bind barrel_shift_stages barrel_shift_chk #(.W(W), .AW(AW)) u_chk (
  .din(din), .amt(amt), .mode(mode), .dout(dout)
);

// File: tb/barrel_shift_stages_tb.sv
module barrel_shift_stages_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [4:0]  amt = '0;
  logic [1:0]  mode = '0;
  logic [31:0] dout;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  barrel_shift_stages u_dut (.din(din), .amt(amt), .mode(mode), .dout(dout));

  function automatic logic [31:0] model(logic [31:0] x, int a, logic [1:0] m);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case (m)
        2'b00: r[i] = (i + a < 32) ? x[i + a] : 1'b0;
        2'b01: r[i] = (i + a < 32) ? x[i + a] : x[31];
        2'b10: r[i] = (i >= a) ? x[i - a] : 1'b0;
        default: r[i] = x[(i + a) % 32];
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (din=%h amt=%0d mode=%b)",
               req, act, exp, din, amt, mode);
    end
  endtask

  task automatic apply(logic [31:0] x, int a, logic [1:0] m);
    @(negedge clk);
    din = x; amt = 5'(a); mode = m;
    #1;
  endtask

  initial begin
    logic [31:0] mid;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    apply('0, 0, 2'b00);
    check("R5", dout, 32'h0);

    for (int m = 0; m < 4; m++) begin
      apply(32'hA5C3_0F96, 0, 2'(m));
      check("R5", dout, 32'hA5C3_0F96);
    end

    apply(32'h8000_0001, 31, 2'b01);
    check("R2", dout, 32'hFFFF_FFFF);
    apply(32'h8000_0000, 31, 2'b00);
    check("R1", dout, 32'h0000_0001);
    apply(32'h7FFF_FFFF, 31, 2'b01);
    check("R2", dout, 32'h0000_0000);
    apply(32'h8000_0001, 1, 2'b10);
    check("R3", dout, 32'h0000_0002);
    apply(32'h0000_0001, 31, 2'b10);
    check("R3", dout, 32'h8000_0000);
    apply(32'h0000_FFFF, 16, 2'b11);
    check("R4", dout, 32'hFFFF_0000);
    apply(32'h8000_0001, 31, 2'b11);
    check("R4", dout, 32'h0000_0003);

    // R6: distance 3 equals 2 then 1, and 21 equals 16 then 5
    for (int m = 0; m < 4; m++) begin
      apply(32'hC0DE_1234, 2, 2'(m));
      mid = dout;
      apply(mid, 1, 2'(m));
      mid = dout;
      apply(32'hC0DE_1234, 3, 2'(m));
      check("R6", dout, mid);
      apply(32'h9876_5431, 16, 2'(m));
      mid = dout;
      apply(mid, 5, 2'(m));
      mid = dout;
      apply(32'h9876_5431, 21, 2'(m));
      check("R6", dout, mid);
    end

    // R7: output settles between clock edges, with no edge in between
    @(negedge clk);
    din = 32'h0000_00F0; amt = 5'd4; mode = 2'b00;
    #1;
    check("R7", dout, 32'h0000_000F);
    din = 32'h0000_0F00;
    #1;
    check("R7", dout, 32'h0000_00F0);

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x;
      int a;
      logic [1:0] m;
      x = $urandom();
      a = $urandom_range(0, 31);
      m = 2'($urandom_range(0, 3));
      if (n % 7 == 0) x[31] = 1'b1;
      apply(x, a, m);
      check(req_of(m), dout, model(x, a, m));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule